// File: doc/BRIEF.md
# Privileged Status Register Write Filter

This block holds a 32-bit privileged status register and decides, on each software write, which bits really change. A write does not only pass through a fixed writable-bit mask. The effective mask also depends on the written value. In revision-6 mode, a reserved privilege-mode encoding is refused, and two sticky bits (soft reset and NMI) refuse a written one. In 64-bit mode, the three address-segment enables form a chain, and turning any of them off asks for a translation-cache flush.

After each accepted write, the block also refreshes one mirrored per-thread status word. It copies in the coprocessor-usable bits, the MX bit and the privilege mode from the new status value, and the current address-space identifier from its input. The bits it does not own keep their values. Two one-cycle pulses report what happened: one marks that a write was taken, and the other requests a flush.

Top module: `stat_wr_filter`

## Requirements
- R1: After reset, `status_q` and `thr_status_q` are all zeros; `flush_req` and `status_upd` are 0.
- R2: On a write, the new status is (old AND NOT m) OR (d AND m). Here d is the write data after the segment chain of R5, and m is `wr_mask` reduced by R3 and R4. Bits outside m never change.
- R3: When `rev6_mode`=1, `wr_mask[4:3]`=2'b11 and `wr_data[4:3]`=2'b11, the privilege field `status_q[4:3]` keeps its old value. If either mask bit is 0, or the mode is 0, the value 3 is written normally where the mask allows.
- R4: When `rev6_mode`=1, a 1 written to bit 20 (soft reset) or bit 19 (NMI) leaves that bit unchanged. A 0 written to either bit clears it if its mask bit is set.
- R5: When `wide_mode`=1, the write data is altered before masking. Bit 6 (supervisor segment) is forced to 0 when bit 7 (kernel segment) is 0, and bit 5 (user segment) is forced to 0 when the resulting bit 6 is 0.
- R6: When `wide_mode`=1 and a write turns any of bits 7, 6 or 5 from 1 to 0, `flush_req` is 1 in the cycle after the write edge and 0 otherwise. It never pulses in 32-bit mode.
- R7: Each write updates the thread word as follows. Bits 31:28 take the new status bits 31:28, bit 27 takes status bit 24 (MX), bits 12:11 take status bits 4:3, and bits 7:0 take `asid`. All other bits keep their values.
- R8: `status_upd` is 1 for exactly the one cycle after every write edge, whether or not the value changed.
- R9: Without `wr_en`, both registers hold their values and neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Value written |
| wr_mask | input | 32 | Configured writable-bit mask |
| rev6_mode | input | 1 | Enables value-dependent suppression (R3, R4) |
| wide_mode | input | 1 | Enables segment chain and flush (R5, R6) |
| asid | input | 8 | Current address-space identifier |
| status_q | output | 32 | Status register |
| thr_status_q | output | 32 | Mirrored per-thread status word |
| flush_req | output | 1 | One-cycle translation-cache flush request |
| status_upd | output | 1 | One-cycle write-taken strobe |

## Verification
The filter is tried under all four combinations of the two mode straps. Each combination gets pseudo-random data and masks, with the mask sometimes fully open, so that mode-dependent suppression can be told apart from plain masking. Directed writes then separate the cases that look alike. The privilege value 3 is written once with only one mask bit open, and the sticky bits are written with 1 and then with 0. The kernel enable is cleared with the supervisor bit left unmasked, and a segment is disabled while 64-bit mode is off, which must give no flush. Idle cycles between writes show that nothing moves without a strobe.

// File: rtl/stat_wr_filter.sv
module stat_wr_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [31:0] wr_mask,
  input  logic        rev6_mode,
  input  logic        wide_mode,
  input  logic [7:0]  asid,
  output logic [31:0] status_q,
  output logic [31:0] thr_status_q,
  output logic        flush_req,
  output logic        status_upd
);
  localparam int KE = 7, SE = 6, UE = 5;
  localparam int PM_LO = 3, SRB = 20, NMIB = 19, MXB = 24;
  localparam int T_MX = 27, T_PM_LO = 11;

  logic [31:0] data_c, mask_c, next_st, next_thr;
  logic        seg_off;

  always_comb begin
    data_c = wr_data;
    if (wide_mode) begin
      data_c[SE] = wr_data[SE] & wr_data[KE];
      data_c[UE] = wr_data[UE] & data_c[SE];
    end
    mask_c = wr_mask;
    if (rev6_mode) begin
      if (wr_mask[PM_LO+1 -: 2] == 2'b11 && wr_data[PM_LO+1 -: 2] == 2'b11)
        mask_c[PM_LO+1 -: 2] = 2'b00;
      mask_c[SRB]  = wr_mask[SRB]  & ~wr_data[SRB];
      mask_c[NMIB] = wr_mask[NMIB] & ~wr_data[NMIB];
    end
  end

  assign next_st = (status_q & ~mask_c) | (data_c & mask_c);
  assign seg_off = wide_mode & |(status_q[KE:UE] & ~next_st[KE:UE]);

  always_comb begin
    next_thr = thr_status_q;
    next_thr[31:28] = next_st[31:28];
    next_thr[T_MX] = next_st[MXB];
    next_thr[T_PM_LO+1 -: 2] = next_st[PM_LO+1 -: 2];
    next_thr[7:0] = asid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q     <= '0;
      thr_status_q <= '0;
      flush_req    <= 1'b0;
      status_upd   <= 1'b0;
    end else begin
      flush_req  <= wr_en & seg_off;
      status_upd <= wr_en;
      if (wr_en) begin
        status_q     <= next_st;
        thr_status_q <= next_thr;
      end
    end
  end
endmodule

module stat_wr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] wr_mask,
  input logic        rev6_mode,
  input logic        wide_mode,
  input logic [31:0] status_q,
  input logic [31:0] thr_status_q,
  input logic        flush_req,
  input logic        status_upd
);
  // R8
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status_upd);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(status_q) && $stable(thr_status_q) && !status_upd && !flush_req));
  // R6
  flush_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wide_mode) |=> !flush_req);
  // R4
  sticky_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rev6_mode && wr_data[20]) |=> $stable(status_q[20]));
  // R4
  sticky_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rev6_mode && wr_data[19]) |=> $stable(status_q[19]));
  // R5
  seg_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wide_mode && !wr_data[7] && wr_mask[6]) |=> !status_q[6]);
  // R7
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_upd |-> (thr_status_q[27] == status_q[24] &&
                    thr_status_q[12:11] == status_q[4:3] &&
                    thr_status_q[31:28] == status_q[31:28]));
endmodule

bind stat_wr_filter stat_wr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .wr_mask(wr_mask), .rev6_mode(rev6_mode), .wide_mode(wide_mode),
  .status_q(status_q), .thr_status_q(thr_status_q),
  .flush_req(flush_req), .status_upd(status_upd)
);

// File: tb/stat_wr_filter_bench.sv
`timescale 1ns/1ps
module stat_wr_filter_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, rev6_mode = 0, wide_mode = 0;
  logic [31:0] wr_data = 0, wr_mask = 0;
  logic [7:0] asid = 0;
  logic [31:0] status_q, thr_status_q;
  logic flush_req, status_upd;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] e_st = 0, e_thr = 0, rng = 32'h1234_5678;

  always #10 clk = ~clk;

  stat_wr_filter u_stat_wr_filter (.*);

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d, logic [31:0] m, logic r6, logic w, logic [7:0] a);
    logic [31:0] dd, mm, ns;
    logic fl;
    dd = d; mm = m;
    if (w) begin
      dd[6] = d[6] & d[7];
      dd[5] = d[5] & dd[6];
    end
    if (r6) begin
      if (m[4] && m[3] && d[4] && d[3]) begin mm[4] = 0; mm[3] = 0; end
      if (d[20]) mm[20] = 0;
      if (d[19]) mm[19] = 0;
    end
    ns = (e_st & ~mm) | (dd & mm);
    fl = w && ((e_st[7] && !ns[7]) || (e_st[6] && !ns[6]) || (e_st[5] && !ns[5]));
    e_st = ns;
    e_thr[31:28] = ns[31:28];
    e_thr[27] = ns[24];
    e_thr[12:11] = ns[4:3];
    e_thr[7:0] = a;
    wr_data = d; wr_mask = m; rev6_mode = r6; wide_mode = w; asid = a; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    chk("R2", status_q, e_st);
    chk("R7", thr_status_q, e_thr);
    chk("R6", {31'b0, flush_req}, {31'b0, fl});
    chk("R8", {31'b0, status_upd}, 32'd1);
  endtask

  task automatic idle();
    wr_data = ~wr_data;
    @(posedge clk); @(negedge clk);
    chk("R9", status_q, e_st);
    chk("R9", thr_status_q, e_thr);
    chk("R9", {30'b0, flush_req, status_upd}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", status_q, 32'd0);
    chk("R1", thr_status_q, 32'd0);
    chk("R1", {30'b0, flush_req, status_upd}, 32'd0);

    for (int md = 0; md < 4; md++) begin
      for (int i = 0; i < 400; i++) begin
        logic [31:0] d, m;
        rng = nxt(rng); d = rng;
        rng = nxt(rng); m = (i % 3 == 0) ? 32'hFFFF_FFFF : rng;
        wr(d, m, md[0], md[1], d[15:8] ^ m[7:0]);
        if (i % 7 == 0) idle();
      end
    end

    // R3: value 3 refused only with both mask bits open in rev6
    wr(32'h0, 32'hFFFF_FFFF, 0, 0, 8'h11);
    wr(32'h8, 32'hFFFF_FFFF, 1, 0, 8'h12);
    wr(32'h18, 32'hFFFF_FFFF, 1, 0, 8'h13);
    chk("R3", {30'b0, status_q[4:3]}, 32'd1);
    wr(32'h18, 32'h0000_0010, 1, 0, 8'h14);
    chk("R3", {30'b0, status_q[4:3]}, 32'd3);
    // R4: sticky bits refuse a one, accept a zero
    wr(32'h0018_0000, 32'hFFFF_FFFF, 0, 0, 8'h15);
    wr(32'h0000_0000, 32'hFFFF_FFFF, 1, 0, 8'h16);
    chk("R4", {30'b0, status_q[20:19]}, 32'd0);
    wr(32'h0018_0000, 32'hFFFF_FFFF, 1, 0, 8'h17);
    chk("R4", {30'b0, status_q[20:19]}, 32'd0);
    // R5 and R6: chain and flush
    wr(32'hE0, 32'hFFFF_FFFF, 0, 1, 8'h18);
    wr(32'h60, 32'hFFFF_FFFF, 0, 1, 8'h19);
    chk("R5", {29'b0, status_q[7:5]}, 32'd0);
    chk("R6", {31'b0, flush_req}, 32'd1);
    idle();
    wr(32'hE0, 32'hFFFF_FFFF, 0, 1, 8'h1A);
    wr(32'h00, 32'hFFFF_FFFF, 0, 0, 8'h1B);
    chk("R6", {31'b0, flush_req}, 32'd0);
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule